// File: doc/BRIEF.md
# Symmetric Five-Tap Bit-Serial FIR Filter

This block is a five-tap FIR filter with mirrored coefficients and no multipliers. Each sample is accepted in parallel and then sent through the datapath one bit per clock, least significant bit first. A frame is fourteen clocks long: twelve data bits and two copies of the sign bit. The bits travel through a chain of five tap shift registers. Two bit-serial full adders add the outer pair and the inner pair of taps. Their sum bits, together with the centre-tap bit, address an eight-entry table of coefficient sums. The table is built at elaboration from three coefficient parameters. A shift-and-accumulate stage weights each table value by its bit position. On the final bit-cycle it subtracts the value instead of adding it, then moves the sum to the output register and clears itself.

The host drives `smp_stb` with `smp_data` at any clock within a frame. The sample enters the datapath at the next frame boundary. Every frame ends with a one-clock `res_valid` pulse and a new full-precision signed result. Frames run back to back from the release of reset. Reset is active low and asynchronous, and a two-stage synchroniser releases it on the clock.

Top module: `da_sym_fir`

## Requirements
- R1: After reset, `res_data` is 0 and `res_valid` is 0. The first result, reported at the end of the first frame, is 0.
- R2: A frame is exactly 14 clocks. `res_valid` is high for one clock per frame, so consecutive pulses are 14 clocks apart.
- R3: The result reported at the end of frame f is CO*(x[f-1]+x[f-5]) + CI*(x[f-2]+x[f-4]) + CC*x[f-3], as a two's-complement value of DATA_W+COEF_W+2 bits. Here CO, CI and CC are the outer, inner and centre coefficients, and x[g] is the sample captured during frame g-1.
- R4: Samples are 12-bit two's complement, and the full range -2048..2047 gives exact results. This includes long runs of the two extremes and alternation between them.
- R5: `res_data` does not change except in the clock where `res_valid` is high.
- R6: A strobe in the last clock of a frame is used for the next frame, in the same way as a strobe earlier in that frame.
- R7: If a frame contains several strobes, only the sample from the last one is used.
- R8: A frame with no strobe sends a zero sample into the tap chain.
- R9: The pre-adder carries do not carry over from one frame to the next. A frame that follows extreme negative or positive pairs gives the same result as it would after a reset.
- R10: A single sample of value v, with zero samples around it, gives the responses v*CO, v*CI, v*CC, v*CI, v*CO on successive frames. This shows that the table comes from the coefficient parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock inside the block |
| smp_stb | input | 1 | Sample strobe; the last strobe of a frame supplies the next sample |
| smp_data | input | DATA_W | Two's-complement input sample |
| res_data | output | DATA_W+COEF_W+2 | Filter result, two's complement |
| res_valid | output | 1 | One-clock pulse marking a new result |

## Verification
The hardest case to reach from the ports is a pre-adder pair whose sum needs the thirteenth bit and whose sign the padding bits must carry correctly. Two -2048 samples in the outer pair, or two +2047 samples, are examples; a carry left at the end of such a frame would corrupt the next one. The stimulus therefore sends runs of each extreme and an alternation between them, with impulse trains before and after. It follows these with a long pseudo-random sequence in which the strobe falls at a different clock of each frame. Strobes on the frame boundary, doubled strobes and empty frames are placed between these blocks, so the capture rules are tested against full-range data already in the taps.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Sum of coefficients selected by a table address:
  // bit 0 = outer-pair sum bit, bit 1 = inner-pair sum bit, bit 2 = centre tap bit
  function automatic int da_entry(input logic [2:0] sel, input int c_out,
                                  input int c_in, input int c_mid);
    int acc;
    acc = 0;
    if (sel[0]) acc = acc + c_out;
    if (sel[1]) acc = acc + c_in;
    if (sel[2]) acc = acc + c_mid;
    return acc;
  endfunction

endpackage

// File: rtl/dafir_rst_sync.sv
module dafir_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dafir_front.sv
module dafir_front #(
  parameter int DATA_W  = 12,
  parameter int FRAME_W = 14,
  parameter int TAPS    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_data,
  output logic [TAPS-1:0]   tap_lsb
);
  localparam int PAD_W = FRAME_W - DATA_W;

  logic [DATA_W-1:0]             hold_q, hold_d;
  logic                          hold_v_q, hold_v_d;
  logic                          hold_en;
  logic [DATA_W-1:0]             next_smp;
  logic [FRAME_W-1:0]            ser_q, ser_d;
  logic [TAPS-1:0][FRAME_W-1:0]  tap_q, tap_d;

  // capture: last strobe in a frame wins; a boundary strobe is forwarded
  always_comb begin
    next_smp = smp_stb ? smp_data : (hold_v_q ? hold_q : '0);
    hold_en  = smp_stb && !frame_end;
    hold_d   = smp_data;
    hold_v_d = hold_v_q;
    if (frame_end)    hold_v_d = 1'b0;
    else if (smp_stb) hold_v_d = 1'b1;
  end

  // serializer: parallel load with sign-extension padding, then shift right
  always_comb begin
    if (frame_end) ser_d = {{PAD_W{next_smp[DATA_W-1]}}, next_smp};
    else           ser_d = {1'b0, ser_q[FRAME_W-1:1]};
  end

  // tap chain: each register takes the previous one's LSB into its MSB
  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      if (t == 0) tap_d[t] = {ser_q[0], tap_q[t][FRAME_W-1:1]};
      else        tap_d[t] = {tap_q[t-1][0], tap_q[t][FRAME_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q   <= '0;
      hold_v_q <= 1'b0;
      ser_q    <= '0;
      tap_q    <= '0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      hold_v_q <= hold_v_d;
      ser_q    <= ser_d;
      tap_q    <= tap_d;
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_lsb
    assign tap_lsb[t] = tap_q[t][0];
  end

  // R4: the bits above the data MSB are copies of the sign after a load
  p_pad_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> ((ser_q[FRAME_W-1:DATA_W-1] == '0) || (ser_q[FRAME_W-1:DATA_W-1] == '1)));

  // R8: a frame without any strobe loads a zero sample
  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !smp_stb && !hold_v_q) |=> (ser_q == '0));

  // R7: a later strobe in the same frame replaces the held sample
  p_last_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !frame_end) |=> (hold_v_q && hold_q == $past(smp_data)));
endmodule

// File: rtl/dafir_sadd.sv
module dafir_sadd (
  input  logic clk,
  input  logic rst_n,
  input  logic first,
  input  logic a,
  input  logic b,
  output logic sum
);
  logic cy_q, cy_d, cin;

  always_comb begin
    cin  = first ? 1'b0 : cy_q;
    sum  = a ^ b ^ cin;
    cy_d = (a & b) | (a & cin) | (b & cin);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cy_q <= 1'b0;
    else        cy_q <= cy_d;
  end

  // R9: the first bit-cycle of a frame ignores the carry left over
  p_first_nocarry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> (sum == (a ^ b)));
endmodule

// File: rtl/dafir_rom.sv
module dafir_rom #(
  parameter int TBL_W    = 10,
  parameter int C_OUTER  = -9,
  parameter int C_INNER  = 37,
  parameter int C_CENTER = 100
) (
  input  logic [2:0]       addr,
  output logic [TBL_W-1:0] data
);
  localparam int NENT = 8;

  logic [NENT-1:0][TBL_W-1:0] ent;

  for (genvar e = 0; e < NENT; e++) begin : g_ent
    assign ent[e] = TBL_W'(dafir_pkg::da_entry(3'(e), C_OUTER, C_INNER, C_CENTER));
  end

  assign data = ent[addr];
endmodule

// File: rtl/dafir_acc.sv
module dafir_acc #(
  parameter int TBL_W   = 10,
  parameter int FRAME_W = 14,
  parameter int OUT_W   = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last,
  input  logic [TBL_W-1:0] tbl,
  output logic [OUT_W-1:0] res_data,
  output logic             res_valid
);
  localparam int ACC_W = TBL_W + FRAME_W + 1;

  logic signed [ACC_W-1:0] tbl_sx, tbl_w, acc_half, acc_sum, acc_q, acc_d;
  logic [OUT_W-1:0]        res_q, res_d;
  logic                    vld_q;

  always_comb begin
    tbl_sx   = {{(ACC_W-TBL_W){tbl[TBL_W-1]}}, tbl};
    tbl_w    = tbl_sx <<< (FRAME_W-1);
    acc_half = acc_q >>> 1;
    acc_sum  = last ? (acc_half - tbl_w) : (acc_half + tbl_w);
    acc_d    = last ? '0 : acc_sum;
    res_d    = acc_sum[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      if (last) res_q <= res_d;
      vld_q <= last;
    end
  end

  assign res_data  = res_q;
  assign res_valid = vld_q;

  // R3: the accumulator starts every frame from zero
  p_acc_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (acc_q == '0));

  // R5: the result only moves at a frame end
  p_res_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(res_q));
endmodule

// File: rtl/da_sym_fir.sv
module da_sym_fir #(
  parameter int DATA_W   = 12,
  parameter int PAD_W    = 2,
  parameter int COEF_W   = 8,
  parameter int C_OUTER  = -9,
  parameter int C_INNER  = 37,
  parameter int C_CENTER = 100
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_stb,
  input  logic [DATA_W-1:0]          smp_data,
  output logic [DATA_W+COEF_W+1:0]   res_data,
  output logic                       res_valid
);
  localparam int TAPS    = 5;
  localparam int NPAIR   = 2;
  localparam int FRAME_W = DATA_W + PAD_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int TBL_W   = COEF_W + 2;
  localparam int OUT_W   = DATA_W + COEF_W + 2;

  logic             rst_n_s;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             frame_end, frame_first;
  logic [TAPS-1:0]  tap_lsb;
  logic [NPAIR-1:0] pair_sum;
  logic [2:0]       tbl_addr;
  logic [TBL_W-1:0] tbl_data;

  dafir_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // bit-cycle counter
  always_comb begin
    frame_end   = (bcnt_q == CNT_W'(FRAME_W-1));
    frame_first = (bcnt_q == '0);
    bcnt_d      = frame_end ? '0 : bcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) bcnt_q <= '0;
    else          bcnt_q <= bcnt_d;
  end

  dafir_front #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .TAPS(TAPS)) u_front (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .frame_end (frame_end),
    .smp_stb   (smp_stb),
    .smp_data  (smp_data),
    .tap_lsb   (tap_lsb)
  );

  // pre-adders on mirrored tap pairs
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    dafir_sadd u_sadd (
      .clk   (clk),
      .rst_n (rst_n_s),
      .first (frame_first),
      .a     (tap_lsb[p]),
      .b     (tap_lsb[TAPS-1-p]),
      .sum   (pair_sum[p])
    );
  end

  assign tbl_addr = {tap_lsb[NPAIR], pair_sum[1], pair_sum[0]};

  dafir_rom #(.TBL_W(TBL_W), .C_OUTER(C_OUTER), .C_INNER(C_INNER),
              .C_CENTER(C_CENTER)) u_rom (
    .addr (tbl_addr),
    .data (tbl_data)
  );

  dafir_acc #(.TBL_W(TBL_W), .FRAME_W(FRAME_W), .OUT_W(OUT_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .last      (frame_end),
    .tbl       (tbl_data),
    .res_data  (res_data),
    .res_valid (res_valid)
  );

  // R2: the counter wraps after the last bit-cycle
  p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    frame_end |=> (bcnt_q == '0));

  // R2: a result pulse lines up with the first bit-cycle of the next frame
  p_valid_align_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> frame_first);

  // R2: the pulse lasts one clock
  p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |=> !res_valid);
endmodule

// File: tb/sim_da_sym_fir.sv
`timescale 1ns/1ps
module sim_da_sym_fir;
  localparam int DATA_W = 12;
  localparam int COEF_W = 8;
  localparam int OUT_W  = DATA_W + COEF_W + 2;
  localparam int CO = -9;
  localparam int CI = 37;
  localparam int CC = 100;
  localparam int FRAME = 14;
  localparam int MAXF = 256;

  logic              clk;
  logic              rst_n;
  logic              smp_stb;
  logic [DATA_W-1:0] smp_data;
  logic [OUT_W-1:0]  res_data;
  logic              res_valid;

  int    checks;
  int    errors;
  bit    done;
  int    xs   [0:MAXF-1];
  string ptag [0:MAXF-1];
  int    fr;
  int    pulse_idx;
  int    since_pulse;
  bit    hold_bad;
  logic [OUT_W-1:0] last_res;
  bit    started;
  logic [15:0] lfsr;

  da_sym_fir #(.DATA_W(DATA_W), .PAD_W(2), .COEF_W(COEF_W),
               .C_OUTER(CO), .C_INNER(CI), .C_CENTER(CC)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .smp_data  (smp_data),
    .res_data  (res_data),
    .res_valid (res_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int xval(input int g);
    if (g < 0 || g >= MAXF) return 0;
    return xs[g];
  endfunction

  function automatic int model(input int j);
    return CO * (xval(j-1) + xval(j-5)) + CI * (xval(j-2) + xval(j-4)) + CC * xval(j-3);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // output monitor
  always @(negedge clk) begin
    if (started) begin
      if (res_valid) begin
        int act;
        int exp;
        act = int'($signed(res_data));
        exp = (pulse_idx < MAXF) ? model(pulse_idx) : 0;
        check(act == exp, (pulse_idx < MAXF) ? ptag[pulse_idx] : "R3", act, exp);
        if (pulse_idx > 0) begin
          check(since_pulse == FRAME, "R2 pulse spacing", since_pulse, FRAME);
          check(!hold_bad, "R5 result held between pulses", int'(hold_bad), 0);
        end
        pulse_idx++;
        since_pulse = 1;
        hold_bad = 1'b0;
        last_res = res_data;
      end else begin
        since_pulse++;
        if (pulse_idx > 0 && res_data != last_res) hold_bad = 1'b1;
      end
    end
  end

  task automatic drive_frame(input int n, input int off1, input int d1,
                             input int off2, input int d2, input string tag);
    int val;
    val = (n == 0) ? 0 : ((n == 1) ? d1 : d2);
    if (fr + 1 < MAXF) xs[fr+1] = val;
    if (fr + 2 < MAXF) ptag[fr+2] = tag;
    for (int c = 0; c < FRAME; c++) begin
      smp_stb  = ((n >= 1) && (c == off1)) || ((n == 2) && (c == off2));
      smp_data = ((n == 2) && (c == off2)) ? DATA_W'(d2) : DATA_W'(d1);
      @(negedge clk);
    end
    smp_stb = 1'b0;
    fr++;
  endtask

  function automatic int lfsr_sample(input logic [15:0] v);
    int s;
    s = int'(v[11:0]);
    if (s >= 2048) s = s - 4096;
    return s;
  endfunction

  initial begin
    checks = 0; errors = 0; done = 1'b0; fr = 0; pulse_idx = 0;
    since_pulse = 0; hold_bad = 1'b0; started = 1'b0; last_res = '0;
    lfsr = 16'hACE1;
    for (int i = 0; i < MAXF; i++) begin
      xs[i] = 0;
      ptag[i] = "R3 filter output";
    end
    ptag[0] = "R1 first result";
    rst_n = 1'b0; smp_stb = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(res_data == '0, "R1 reset result", int'($signed(res_data)), 0);
    check(res_valid == 1'b0, "R1 reset valid", int'(res_valid), 0);
    started = 1'b1;
    while (!res_valid) @(negedge clk);
    // now in the first clock of frame 1
    fr = 1;

    // R10: impulse responses, empty frames around them (R8)
    drive_frame(1, 4, 1, 0, 0, "R10 impulse +1");
    for (int k = 0; k < 6; k++) drive_frame(0, 0, 0, 0, 0, "R8 empty frame");
    drive_frame(1, 7, -1, 0, 0, "R10 impulse -1");
    for (int k = 0; k < 6; k++) drive_frame(0, 0, 0, 0, 0, "R8 empty frame");

    // R4 / R9: extreme runs and alternation
    for (int k = 0; k < 6; k++) drive_frame(1, 2, -2048, 0, 0, "R4 min run");
    for (int k = 0; k < 6; k++) drive_frame(1, 11, 2047, 0, 0, "R4 max run");
    for (int k = 0; k < 8; k++)
      drive_frame(1, 5, (k % 2 == 0) ? -2048 : 2047, 0, 0, "R9 alternating extremes");
    drive_frame(1, 3, 5, 0, 0, "R9 small after extremes");
    for (int k = 0; k < 5; k++) drive_frame(0, 0, 0, 0, 0, "R9 drain after extremes");

    // R6: strobe on the last clock and on the first clock of a frame
    drive_frame(1, 13, 321, 0, 0, "R6 boundary strobe");
    drive_frame(1, 0, -654, 0, 0, "R6 first-clock strobe");
    drive_frame(1, 13, -2048, 0, 0, "R6 boundary strobe extreme");

    // R7: two strobes in one frame, including one at the boundary
    drive_frame(2, 2, 1234, 9, -777, "R7 second strobe wins");
    drive_frame(2, 1, -1500, 13, 999, "R7 boundary second strobe wins");
    drive_frame(0, 0, 0, 0, 0, "R8 empty after double");

    // R3: pseudo-random samples with rotating strobe position
    for (int k = 0; k < 120; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      drive_frame(1, k % FRAME, lfsr_sample(lfsr), 0, 0, "R3 random sample");
    end
    for (int k = 0; k < 7; k++) drive_frame(0, 0, 0, 0, 0, "R8 final drain");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule